// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. The character arrives through a valid/ready handshake. A one-cycle baud enable, pulsing sixteen times per bit period, paces the frame. The shape of each frame comes from a small set of framing inputs:

- character length of five to eight bits;
- an optional parity bit, with even, odd or stuck sense;
- one stop bit or an extended stop period;
- a break override.

The framing inputs are captured when the character is accepted. The break override acts on the pin live. It pulls the line low, but the frame sequencing keeps running.

The line rests high. A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then the stop period. Busy is high from the cycle after acceptance until the last stop tick has been consumed.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, tx_out is 1, tx_busy is 0 and in_ready is 1.
- R2: In the cycle after acceptance, the line carries a 0 start bit. The data bits follow, least significant first. The start bit and each data bit each last 16 baud ticks.
- R3: cfg_len selects the number of data bits sent: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the selected length are not sent.
- R4: With cfg_par_en at 0, no parity bit is sent. With cfg_par_en at 1, one 16-tick parity bit follows the last data bit.
- R5: With parity enabled and cfg_stick at 0, the parity bit makes the count of ones in the data plus parity bits even when cfg_even is 1, and odd when cfg_even is 0.
- R6: With parity enabled and cfg_stick at 1, the parity bit is the inverse of cfg_even, whatever the data.
- R7: With cfg_par_en at 0, the values of cfg_even and cfg_stick do not change the frame.
- R8: With cfg_stop2 at 0, the stop period is 16 ticks of logic 1. With cfg_stop2 at 1, it is 24 ticks for 5-bit characters and 32 ticks for the other lengths. tx_busy falls once the last stop tick has been consumed.
- R9: While cfg_break is 1, tx_out is 0. The frame still completes after exactly the tick count it would have taken without break.
- R10: The framing inputs and the character are sampled at acceptance. Changing them during a frame does not alter that frame.
- R11: in_ready is 1 only while the block is idle. A character is taken on a cycle with in_valid and in_ready both high. in_valid is ignored while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit period |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_even | input | 1 | Even parity select |
| cfg_stick | input | 1 | Stuck parity select |
| cfg_stop2 | input | 1 | Extended stop period select |
| cfg_break | input | 1 | Force the line low |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character, LSB sent first |
| in_ready | output | 1 | Block can accept a character |
| tx_out | output | 1 | Serial line |
| tx_busy | output | 1 | Frame in progress |

## Verification
Two functions can fall in the same cycle: the break override acting on the pin, and the frame sequencer advancing or finishing on a baud tick. The bench holds break high across an entire frame, including the tick that ends the stop period. It then requires three things: the line stays low on every tick, tx_busy falls after exactly the tick count of the same frame without break, and the line returns high as soon as break is released. A second collision is a new in_valid, with altered framing inputs, presented while a frame is running. The running frame must keep its captured format bit for bit.

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_even,
  input  logic       cfg_stick,
  input  logic       cfg_stop2,
  input  logic       cfg_break,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       tx_out,
  output logic       tx_busy
);
  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic [1:0]    len_q;
  logic          pen_q, stop2_q, par_q;
  logic [7:0]    dmask;
  logic          par_nxt, line_bit, bit_end;
  logic [CW-1:0] last_cnt;

  always_comb begin
    case (cfg_len)
      2'b00:   dmask = 8'h1F;
      2'b01:   dmask = 8'h3F;
      2'b10:   dmask = 8'h7F;
      default: dmask = 8'hFF;
    endcase
  end

  assign par_nxt = cfg_stick ? ~cfg_even
                 : (cfg_even ? ^(in_data & dmask) : ~^(in_data & dmask));

  always_comb begin
    if (st != S_STOP)      last_cnt = BIT_LAST;
    else if (!stop2_q)     last_cnt = BIT_LAST;
    else if (len_q == 2'b00) last_cnt = HALF_LAST;
    else                   last_cnt = TWO_LAST;
  end

  assign bit_end  = baud_tick && (cnt == last_cnt);
  assign in_ready = (st == S_IDLE);
  assign tx_busy  = (st != S_IDLE);

  always_comb begin
    case (st)
      S_START: line_bit = 1'b0;
      S_DATA:  line_bit = shreg[0];
      S_PAR:   line_bit = par_q;
      default: line_bit = 1'b1;
    endcase
  end

  assign tx_out = line_bit & ~cfg_break;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      len_q   <= '0;
      pen_q   <= 1'b0;
      stop2_q <= 1'b0;
      par_q   <= 1'b0;
    end else if (st == S_IDLE) begin
      if (in_valid) begin
        st      <= S_START;
        cnt     <= '0;
        idx     <= '0;
        shreg   <= in_data;
        len_q   <= cfg_len;
        pen_q   <= cfg_par_en;
        stop2_q <= cfg_stop2;
        par_q   <= par_nxt;
      end
    end else if (baud_tick) begin
      if (!bit_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
            if (idx == {1'b1, len_q}) st <= pen_q ? S_PAR : S_STOP;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_break,
  input logic tx_out,
  input logic tx_busy
);
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_break) |=> (!tx_out && tx_busy));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !baud_tick) |=> tx_busy);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !cfg_break) |-> tx_out);

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |-> !tx_out);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tx_busy);

  p_no_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !in_valid) |=> !tx_busy);
endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (.*);

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_stick = 1'b0;
  logic       cfg_stop2 = 1'b0, cfg_break = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, tx_out, tx_busy;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  uart_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_even(cfg_even), .cfg_stick(cfg_stick),
    .cfg_stop2(cfg_stop2), .cfg_break(cfg_break), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .tx_out(tx_out), .tx_busy(tx_busy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [1:0] len,
                           input logic pen, input logic ev, input logic stk,
                           input logic s2, input logic brk, input logic disturb,
                           input string req);
    int nb, stop_t, total, ix;
    logic pb, e;
    logic [7:0] m;
    nb     = 5 + int'(len);
    m      = 8'hFF >> (8 - nb);
    pb     = stk ? ~ev : (ev ? ^(d & m) : ~^(d & m));
    stop_t = !s2 ? 16 : (len == 2'b00 ? 24 : 32);
    total  = 16 * (1 + nb + int'(pen)) + stop_t;
    @(negedge clk);
    check({req, " R11 ready before send"}, in_ready, 1'b1);
    cfg_len = len; cfg_par_en = pen; cfg_even = ev; cfg_stick = stk;
    cfg_stop2 = s2; cfg_break = brk; in_data = d; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (disturb) begin
      cfg_len = ~len; cfg_par_en = ~pen; cfg_even = ~ev; cfg_stick = ~stk;
      cfg_stop2 = ~s2; in_data = ~d; in_valid = 1'b1;
    end
    for (int k = 0; k < total; k++) begin
      ix = k / 16;
      if (ix == 0) e = 1'b0;
      else if (ix <= nb) e = d[ix-1];
      else if (pen && ix == nb + 1) e = pb;
      else e = 1'b1;
      if (brk) e = 1'b0;
      check({req, " line"}, tx_out, e);
      check({req, " R8 busy during frame"}, tx_busy, 1'b1);
      if (k == total - 1) in_valid = 1'b0;
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      @(negedge clk);
    end
    check({req, " R8 busy falls at end"}, tx_busy, 1'b0);
    check({req, " R11 ready at end"}, in_ready, 1'b1);
    check({req, " R9 line at end"}, tx_out, ~brk);
    cfg_break = 1'b0;
    #1;
    check({req, " R9 line after break release"}, tx_out, 1'b1);
  endtask

  task automatic t_reset;
    check("R1 line", tx_out, 1'b1);
    check("R1 busy", tx_busy, 1'b0);
    check("R1 ready", in_ready, 1'b1);
  endtask

  task automatic t_lengths;
    for (int l = 0; l < 4; l++)
      run_frame(8'hB5 ^ 8'(l), 2'(l), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R3");
  endtask

  task automatic t_parity;
    run_frame(8'h5A, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R5 even");
    run_frame(8'h5A, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R5 odd");
    run_frame(8'hE3, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 masked");
    run_frame(8'h07, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 odd7");
  endtask

  task automatic t_stick;
    run_frame(8'h01, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 mark");
    run_frame(8'h01, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 space");
    run_frame(8'h3C, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 off");
  endtask

  task automatic t_stop;
    run_frame(8'h96, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 half");
    run_frame(8'h96, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 two");
    run_frame(8'h96, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 two par");
  endtask

  task automatic t_break;
    run_frame(8'hFF, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 break");
    run_frame(8'h00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 break half");
  endtask

  task automatic t_disturb;
    run_frame(8'hA7, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 R11 held");
    run_frame(8'h4D, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 R11 held2");
  endtask

  initial begin
    #1;
    t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_lengths;
    t_parity;
    t_stick;
    t_stop;
    t_break;
    t_disturb;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule